// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit supervision timer for a processor subsystem. A free-running prescaler divides the system clock, and a 3-bit select field picks one of eight taps from it. While the timer is running, an 8-bit up-counter advances once per period of the chosen tap. When the counter wraps from 0xFF to 0x00, the block takes one of two actions, chosen by a mode bit:

- **Watchdog mode:** it sets a watchdog flag. If reset generation is enabled, it also drives a reset request for a fixed number of cycles.
- **Interval mode:** it sets an interval flag, which can raise an interrupt.

Software reaches three byte registers over a small bus: a control byte, the counter byte and a reset-control byte. Writes must be 16-bit words whose upper byte is a key and whose lower byte is the data. Reads must be single bytes, and the read addresses differ from the write addresses. Both flags can only be cleared, by writing 0 to their bit.

Top module: `wd_interval_timer`

## Requirements
- R1: After reset the control byte reads 0x18, the counter reads 0x00, the reset-control byte reads 0x1F, and both `wdt_rst_o` and `irq_o` are low.
- R2: Writes take effect only when `wr_size` is 1 (word) and the upper data byte is 0xA5 or 0x5A; byte (0), long (2) and code-3 writes, and words with any other key, change nothing. Write address 0 holds the control byte and the counter; write address 2 holds the reset-control byte.
- R3: Reads return data only when `rd_size` is 0 (byte): address 0 gives the control byte, 1 the counter, 3 the reset-control byte. Any other size, address 2, or `rd_en` low returns 0x00.
- R4: The control byte is {bit7 interval flag, bit6 mode (1 = watchdog), bit5 run, bit4 interrupt enable, bit3 always reads 1, bits2:0 tap select}. Key 0xA5 at write address 0 loads bits 6,5,4 and 2:0 from the data byte.
- R5: Key 0x5A at write address 0 loads the counter from the data byte while run is 1. While run is 0 the counter is held at 0x00 on every edge, and loads are ignored.
- R6: Tap select 0..7 gives divisors 2, 64, 128, 256, 512, 1024, 4096 and 8192. Counting edges from 0 at the first edge after reset release, a running counter advances at edge n exactly when n+1 is a multiple of the divisor.
- R7: In interval mode, an overflow sets control bit7 at the overflow edge. The counter reads 0x00 after the overflow. `irq_o` is high exactly while control bit7 and bit4 are both 1.
- R8: In watchdog mode, an overflow sets reset-control bit7. If reset-control bit6 is 1, `wdt_rst_o` goes high at the overflow edge and stays high for exactly 128 clock cycles; otherwise it stays low.
- R9: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. An overflow on the same edge as a clearing write leaves the flag set.
- R10: The reset-control byte is {bit7 watchdog flag, bit6 reset enable, bit5 stored select, bits4:0 read as 1}. Key 0x5A at write address 2 loads bits 6:5. Key 0xA5 at write address 2 only clears the flag (per R9).
- R11: A counter load on an edge where the tap fires takes priority over the increment, and that edge produces no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Write transfer size code (0 byte, 1 word, 2 long) |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data: key in bits 15:8, data in 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_size | input | 2 | Read transfer size code |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wdt_rst_o | output | 1 | Watchdog reset request |
| irq_o | output | 1 | Interval interrupt request |

## Verification
The assertions assume that a counter load only matters while run is set, and that the bus strobes are clean levels sampled at the rising edge; they never reason about several writes landing on one edge, because there is only one write port. The stimulus changes the bus only on falling edges and holds each strobe for exactly one rising edge. It times the flag-clear and counter-load races by tracking the tap phase from reset release, so that these writes land on chosen tick or non-tick edges. The overflow spacing at the fastest tap (512 cycles) is kept well above the 128-cycle reset pulse, so the pulse-length checks never see a reload.

// File: rtl/wit_pkg.sv
package wit_pkg;
  localparam int PRESC_W = 13;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int BYTE_W  = 8;
  localparam int BUS_W   = 2 * BYTE_W;
  localparam int NTAPS   = 8;
  localparam int SEL_W   = $clog2(NTAPS);
  localparam int PULSE_CYCLES = 128;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } xfer_size_e;

  localparam logic [BYTE_W-1:0] KEY_CFG  = 8'hA5;
  localparam logic [BYTE_W-1:0] KEY_DATA = 8'h5A;

  localparam logic [ADDR_W-1:0] WA_MAIN = 2'd0;
  localparam logic [ADDR_W-1:0] WA_RCS  = 2'd2;
  localparam logic [ADDR_W-1:0] RA_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] RA_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] RA_RCS  = 2'd3;

  typedef struct packed {
    logic             flag;
    logic             wd_mode;
    logic             run;
    logic             irq_en;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  typedef struct packed {
    logic flag;
    logic rst_en;
    logic rst_sel;
  } rcs_t;

  // log2 of the divisor for each tap select value
  function automatic int tap_order(input int sel);
    case (sel)
      0:       return 1;
      1:       return 6;
      2:       return 7;
      3:       return 8;
      4:       return 9;
      5:       return 10;
      6:       return 12;
      default: return 13;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ctl(input ctl_t c);
    return {c.flag, c.wd_mode, c.run, c.irq_en, 1'b1, c.sel};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_rcs(input rcs_t r);
    return {r.flag, r.rst_en, r.rst_sel, 5'b11111};
  endfunction
endpackage

// File: rtl/wit_prescaler.sv
module wit_prescaler
  import wit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_evt
);
  logic [PRESC_W-1:0] presc_q;
  logic [NTAPS-1:0]   tap_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_q + 1'b1;
  end

  // a tap fires on the last cycle of each of its periods
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    localparam int K = tap_order(g);
    assign tap_fire[g] = &presc_q[K-1:0];
  end

  assign tick_evt = tap_fire[sel];
endmodule

// File: rtl/wit_counter.sv
module wit_counter
  import wit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_evt,
  input  logic             ld_evt,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);
  assign ovf_evt = run & ~ld_evt & tick_evt & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (ld_evt)   cnt_q <= ld_val;
    else if (tick_evt) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wit_regs.sv
module wit_regs
  import wit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              ovf_evt,
  output logic              wr_ctl_evt,
  output logic              wr_cnt_evt,
  output logic              wr_rflag_evt,
  output logic              wr_rcfg_evt,
  output ctl_t              ctl,
  output rcs_t              rcs
);
  logic              word_wr;
  logic [BYTE_W-1:0] key;
  logic [BYTE_W-1:0] dat;
  logic              ovf_iv;
  logic              ovf_wd;

  assign word_wr = wr_en && (wr_size == SZ_WORD);
  assign key     = wr_data[BUS_W-1:BYTE_W];
  assign dat     = wr_data[BYTE_W-1:0];

  assign wr_ctl_evt   = word_wr && (wr_addr == WA_MAIN) && (key == KEY_CFG);
  assign wr_cnt_evt   = word_wr && (wr_addr == WA_MAIN) && (key == KEY_DATA);
  assign wr_rflag_evt = word_wr && (wr_addr == WA_RCS)  && (key == KEY_CFG);
  assign wr_rcfg_evt  = word_wr && (wr_addr == WA_RCS)  && (key == KEY_DATA);

  assign ovf_iv = ovf_evt & ~ctl.wd_mode;
  assign ovf_wd = ovf_evt &  ctl.wd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '{flag: 1'b0, wd_mode: 1'b0, run: 1'b0, irq_en: 1'b1, sel: '0};
      rcs <= '{flag: 1'b0, rst_en: 1'b0, rst_sel: 1'b0};
    end else begin
      if (ovf_iv)                           ctl.flag <= 1'b1;
      else if (wr_ctl_evt && !dat[BYTE_W-1]) ctl.flag <= 1'b0;
      if (wr_ctl_evt) begin
        ctl.wd_mode <= dat[6];
        ctl.run     <= dat[5];
        ctl.irq_en  <= dat[4];
        ctl.sel     <= dat[SEL_W-1:0];
      end
      if (ovf_wd)                             rcs.flag <= 1'b1;
      else if (wr_rflag_evt && !dat[BYTE_W-1]) rcs.flag <= 1'b0;
      if (wr_rcfg_evt) begin
        rcs.rst_en  <= dat[6];
        rcs.rst_sel <= dat[5];
      end
    end
  end
endmodule

// File: rtl/wit_pulse.sv
module wit_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (start)        left_q <= CW'(LEN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/wd_interval_timer.sv
module wd_interval_timer
  import wit_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_size,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BUS_W-1:0]    wr_data,
  input  logic                rd_en,
  input  logic [1:0]          rd_size,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                wdt_rst_o,
  output logic                irq_o
);
  ctl_t             ctl;
  rcs_t             rcs;
  logic             tick_evt;
  logic             ovf_evt;
  logic             wr_ctl_evt;
  logic             wr_cnt_evt;
  logic             wr_rflag_evt;
  logic             wr_rcfg_evt;
  logic             pulse_start;
  logic [CNT_W-1:0] cnt_q;

  wit_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_size(wr_size), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovf_evt(ovf_evt),
    .wr_ctl_evt(wr_ctl_evt), .wr_cnt_evt(wr_cnt_evt),
    .wr_rflag_evt(wr_rflag_evt), .wr_rcfg_evt(wr_rcfg_evt),
    .ctl(ctl), .rcs(rcs)
  );

  wit_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .sel(ctl.sel), .tick_evt(tick_evt)
  );

  wit_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .tick_evt(tick_evt),
    .ld_evt(wr_cnt_evt), .ld_val(wr_data[CNT_W-1:0]),
    .cnt_q(cnt_q), .ovf_evt(ovf_evt)
  );

  assign pulse_start = ovf_evt & ctl.wd_mode & rcs.rst_en;

  wit_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(pulse_start), .active(wdt_rst_o)
  );

  assign irq_o = ctl.flag & ctl.irq_en;

  always_comb begin
    rd_data = '0;
    if (rd_en && (rd_size == SZ_BYTE)) begin
      case (rd_addr)
        RA_CTL:  rd_data = pack_ctl(ctl);
        RA_CNT:  rd_data = cnt_q;
        RA_RCS:  rd_data = pack_rcs(rcs);
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/wit_checker.sv
module wit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_evt,
  input logic       ovf_evt,
  input logic       ld_evt,
  input logic       wr_ctl_evt,
  input logic       wr_rflag_evt,
  input logic       run,
  input logic       wd_mode,
  input logic       rst_en,
  input logic       ctl_flag,
  input logic       wdog_flag,
  input logic [7:0] cnt,
  input logic       wdt_rst_o
);
  p_stopped_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == 8'h00);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick_evt && !ld_evt |=> cnt == 8'($past(cnt) + 8'd1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick_evt && !ld_evt |=> $stable(cnt));

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt == 8'h00);

  p_iv_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !wd_mode |=> ctl_flag);

  p_wd_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && wd_mode |=> wdog_flag);

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && wd_mode && rst_en |=> wdt_rst_o);

  p_ctl_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_flag && !wr_ctl_evt |=> ctl_flag);

  p_wdog_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_flag && !wr_rflag_evt |=> wdog_flag);
endmodule

bind wd_interval_timer wit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_evt(tick_evt), .ovf_evt(ovf_evt),
  .ld_evt(wr_cnt_evt), .wr_ctl_evt(wr_ctl_evt), .wr_rflag_evt(wr_rflag_evt),
  .run(ctl.run), .wd_mode(ctl.wd_mode), .rst_en(rcs.rst_en),
  .ctl_flag(ctl.flag), .wdog_flag(rcs.flag), .cnt(cnt_q),
  .wdt_rst_o(wdt_rst_o)
);

// File: tb/wd_interval_timer_tb.sv
module wd_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_size = 2'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [7:0]  rd_data;
  logic        wdt_rst_o;
  logic        irq_o;

  always #4 clk = ~clk;

  wd_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_size(rd_size),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst_o(wdt_rst_o), .irq_o(irq_o)
  );

  int checks = 0;
  int fails  = 0;

  // reference state, built from the requirements
  int n = 0;
  bit m_flag = 0, m_mode = 0, m_run = 0, m_ie = 1;
  int m_sel = 0, m_cnt = 0, m_pulse = 0;
  bit m_wflag = 0, m_rste = 0, m_rsel = 0;

  typedef struct { int exp; string tag; } item_t;
  item_t sb[$];

  function automatic int divisor(input int s);
    int tbl[8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};
    return tbl[s];
  endfunction

  function automatic int model_read(input int a, input int sz);
    if (sz != 0) return 0;
    case (a)
      0: return m_flag*128 + m_mode*64 + m_run*32 + m_ie*16 + 8 + m_sel;
      1: return m_cnt;
      3: return m_wflag*128 + m_rste*64 + m_rsel*32 + 31;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; m_flag = 0; m_mode = 0; m_run = 0; m_ie = 1; m_sel = 0;
      m_cnt = 0; m_pulse = 0; m_wflag = 0; m_rste = 0; m_rsel = 0;
    end else begin
      bit word, wctl, wcnt, wrf, wrc, tk, ov;
      int key, d, nc;
      word = wr_en && wr_size == 2'd1;
      key  = int'(wr_data[15:8]);
      d    = int'(wr_data[7:0]);
      wctl = word && wr_addr == 2'd0 && key == 'hA5;
      wcnt = word && wr_addr == 2'd0 && key == 'h5A;
      wrf  = word && wr_addr == 2'd2 && key == 'hA5;
      wrc  = word && wr_addr == 2'd2 && key == 'h5A;
      tk   = ((n + 1) % divisor(m_sel)) == 0;
      ov   = m_run && !wcnt && tk && m_cnt == 255;
      if (!m_run)    nc = 0;
      else if (wcnt) nc = d;
      else if (tk)   nc = (m_cnt + 1) % 256;
      else           nc = m_cnt;
      if (ov && m_mode && m_rste) m_pulse = 128;
      else if (m_pulse > 0)       m_pulse = m_pulse - 1;
      if (ov && !m_mode)            m_flag = 1;
      else if (wctl && d < 128)     m_flag = 0;
      if (ov && m_mode)             m_wflag = 1;
      else if (wrf && d < 128)      m_wflag = 0;
      if (wctl) begin
        m_mode = d[6]; m_run = d[5]; m_ie = d[4]; m_sel = d % 8;
      end
      if (wrc) begin m_rste = d[6]; m_rsel = d[5]; end
      m_cnt = nc;
      n = n + 1;
    end
  end

  // scoreboard monitor for reads
  always @(negedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(int'(rd_data) == it.exp, it.tag, int'(rd_data), it.exp);
    end
  end

  // output monitor: R7 interrupt level, R8 reset level and length
  int run_len = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(irq_o == (m_flag && m_ie), "R7 irq_o level", irq_o, m_flag && m_ie);
      chk(wdt_rst_o == (m_pulse > 0), "R8 wdt_rst_o level", wdt_rst_o, m_pulse > 0);
      if (wdt_rst_o) run_len++;
      else if (run_len > 0) begin
        chk(run_len == 128, "R8 reset pulse length", run_len, 128);
        run_len = 0;
      end
    end
  end

  task automatic wr_now(input int a, input int sz, input int data);
    wr_en = 1'b1; wr_addr = 2'(a); wr_size = 2'(sz); wr_data = 16'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input int a, input int data, input int sz = 1);
    @(negedge clk);
    wr_now(a, sz, data);
  endtask

  task automatic rd(input int a, input string tag, input int sz = 0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'(a); rd_size = 2'(sz);
    sb.push_back('{exp: model_read(a, sz), tag: tag});
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  // wait until the next rising edge is (want=1) or is not (want=0) a tap edge
  task automatic align(input bit want);
    @(negedge clk);
    while ((((n + 1) % divisor(m_sel)) == 0) != want) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(0, "R1 ctl reset");
    rd(1, "R1 cnt reset");
    rd(3, "R1 rcs reset");
    // R3 size and address filtering on reads
    rd(2, "R3 unmapped read addr");
    rd(0, "R3 word read returns zero", 1);
    rd(3, "R3 long read returns zero", 2);
    // R2 filtered writes
    wr(0, 'hA53F, 0);
    wr(0, 'hA53F, 2);
    wr(0, 'h123F);
    wr(2, 'h5A60, 3);
    rd(0, "R2 ctl unchanged");
    rd(3, "R2 rcs unchanged");
    // R5 load ignored while stopped
    wr(0, 'h5A40);
    rd(1, "R5 load ignored when stopped");
    // R4 control layout, R6 slow tap
    wr(0, 'hA532);
    rd(0, "R4 ctl layout");
    wr(0, 'h5A10);
    rd(1, "R5 counter load");
    idle(300);
    rd(1, "R6 div128 count");
    // R7 interval overflow
    wr(0, 'hA530);
    wr(0, 'h5AFC);
    idle(12);
    rd(0, "R7 interval flag set");
    rd(1, "R7 counter after wrap");
    // R9 write 1 keeps, write 0 clears
    wr(0, 'hA5B0);
    rd(0, "R9 write one keeps flag");
    wr(0, 'hA530);
    rd(0, "R9 write zero clears flag");
    // R7 interrupt masked
    wr(0, 'hA520);
    wr(0, 'h5AFE);
    idle(10);
    rd(0, "R7 flag with irq disabled");
    // R11 load wins over tick
    wr(0, 'hA520);
    align(0); wr_now(0, 1, 'h5AFF);
    align(1); wr_now(0, 1, 'h5A80);
    rd(0, "R11 no overflow on load edge");
    rd(1, "R11 load value kept");
    // R9 overflow beats clear on the same edge
    align(0); wr_now(0, 1, 'h5AFF);
    align(1); wr_now(0, 1, 'hA520);
    rd(0, "R9 overflow wins over clear");
    // R5 stop clears counter
    wr(0, 'hA500);
    rd(1, "R5 stopped counter zero");
    rd(0, "R5 ctl after stop");
    // R8 watchdog without reset enable
    wr(0, 'hA560);
    wr(0, 'h5AFE);
    idle(10);
    rd(3, "R8 watchdog flag set");
    rd(0, "R8 interval flag untouched");
    // R9 / R10 watchdog flag clearing
    wr(2, 'hA580);
    rd(3, "R9 wflag write one keeps");
    wr(2, 'hA500);
    rd(3, "R10 wflag cleared");
    wr(2, 'h5A60);
    rd(3, "R10 enable and select stored");
    wr(2, 'hA57F);
    rd(3, "R10 key A5 touches only flag");
    // R8 reset pulse
    wr(0, 'h5AFE);
    idle(200);
    rd(3, "R8 flag after reset pulse");
    wr(0, 'hA500);
    wr(2, 'hA500);
    // R6 slowest tap
    wr(0, 'hA527);
    wr(0, 'h5AFD);
    idle(3 * 8192 + 100);
    rd(0, "R6 div8192 overflow flag");
    rd(1, "R6 div8192 count");
    // R6 remaining taps
    for (int s = 1; s < 7; s++) begin
      wr(0, 'hA520 + s);
      wr(0, 'h5A00);
      idle(3000);
      rd(1, $sformatf("R6 tap select %0d count", s));
    end
    wr(0, 'hA500);
    idle(4);
    finish_run();
  end
endmodule